// File: doc/BRIEF.md
# Vector Graphics-Format Unpack Unit

This unit takes a 128-bit source vector and expands a compact vertex or colour encoding into four 32-bit single-precision lanes. The encoding sits in the low-order word or words of the source. A small kind code selects one of four formats:

- 8-bit ARGB colour
- a pair of signed 16-bit integers
- a pair of half-precision floats
- four half-precision floats

Colour channels and integers are not converted arithmetically. Each one is placed into the mantissa of a fixed biased float, either 1.0 or 3.0. Lanes that the format leaves unused are filled with the constants 0.0 and 1.0.

Operands arrive on a valid/ready stream, and results leave on a valid/ready stream through one register stage. A source is taken in the cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty, or is being emptied in the same cycle. A result presented with `out_valid` stays unchanged, together with its error flag, until `out_ready` accepts it. A consumer that holds `out_ready` low therefore stalls the input side after one item, and no data is lost.

Source word k occupies bits `[32k+31:32k]`. Result lane k occupies the same bit range of `out_data`.

Top module: `gfx_unpack_unit`

## Requirements
- R1: A source is captured on a clock edge where `in_valid` and `in_ready` are high, and its result is on `out_data` with `out_valid` high after that edge. `in_ready` is low while a result waits with `out_ready` low.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_err` keep their values on the next cycle.
- R3: After reset, `out_valid` is low and `in_ready` is high.
- R4: Kind 0 (colour) reads word 3 as bytes A,R,G,B from bit 31 down to bit 0. Lanes 0..3 become R,G,B,A, each equal to 0x3F800000 with its unsigned byte in bits [7:0]; for example, 0x04010203 gives lanes 0x3F800001, 0x3F800002, 0x3F800003, 0x3F800004.
- R5: Kind 1 (integer pair) takes bits [31:16] of word 3 for lane 0 and bits [15:0] for lane 1. Each lane is 0x40400000 plus the sign-extended 16-bit value; for example, 0x8001 gives 0x403F8001.
- R6: For kinds 1 and 3, lane 2 is 0x00000000 and lane 3 is 0x3F800000.
- R7: Kind 3 (half pair) converts bits [31:16] of word 3 into lane 0 and bits [15:0] into lane 1.
- R8: Kind 5 (four halves) converts word 2 bits [31:16] into lane 0, word 2 bits [15:0] into lane 1, word 3 bits [31:16] into lane 2, and word 3 bits [15:0] into lane 3.
- R9: A normal half keeps its sign, has its exponent raised by 112, and has its mantissa shifted left by 13 bits; for example, 0xB801 gives 0xBF002000.
- R10: A half with zero exponent and a nonzero mantissa is normalised to an exact single-precision value (0x0001 gives 0x33800000). A signed zero keeps its sign.
- R11: A half with exponent 31 gives single exponent 255, with the sign kept and the mantissa shifted up by 13 bits (0x7C00 gives 0x7F800000, 0xFE01 gives 0xFFC02000).
- R12: Source words that the selected kind does not read have no effect on the result.
- R13: Any kind other than 0, 1, 3 or 5 gives an all-zero `out_data` with `out_err` high. Supported kinds give `out_err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source operand offered |
| in_ready | output | 1 | Unit can take a source this cycle |
| in_src | input | 128 | Source vector, word k at bits [32k+31:32k] |
| in_kind | input | TYPE_W (3) | Format selector |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 128 | Four single-precision lanes, lane k at bits [32k+31:32k] |
| out_err | output | 1 | Kind was not supported |

## Verification
The bench builds the unit with its default `TYPE_W` of 3. With that width all eight kind codes can be driven, so the four unsupported codes that must yield zero with an error are reached alongside the four valid formats. The consumer's ready follows a pseudo-random pattern, with one forced stall, so hold and back-pressure are exercised while results carry denormal, infinite, NaN and signed-zero halves, and while the unread source words hold varying junk.

// File: rtl/gfxu_pkg.sv
package gfxu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = 4;
  localparam int unsigned VEC_W  = WORD_W * LANES;
  localparam int unsigned HALF_W = 16;

  localparam int unsigned KIND_COLOR  = 0;
  localparam int unsigned KIND_SHORT2 = 1;
  localparam int unsigned KIND_HALF2  = 3;
  localparam int unsigned KIND_HALF4  = 5;

  localparam logic [WORD_W-1:0] F_ZERO  = 32'h0000_0000;
  localparam logic [WORD_W-1:0] F_ONE   = 32'h3F80_0000;
  localparam logic [WORD_W-1:0] F_THREE = 32'h4040_0000;

  typedef struct packed {
    logic             err;
    logic [VEC_W-1:0] data;
  } unpack_res_t;
endpackage

// File: rtl/gfxu_half_to_single.sv
module gfxu_half_to_single
  import gfxu_pkg::*;
(
  input  logic [HALF_W-1:0] h_in,
  output logic [WORD_W-1:0] f_out
);
  logic       sgn;
  logic [4:0] hexp;
  logic [9:0] hman;
  logic [3:0] lead;
  logic [10:0] shifted;
  logic [7:0] den_exp;

  assign sgn  = h_in[15];
  assign hexp = h_in[14:10];
  assign hman = h_in[9:0];

  // position of the highest set mantissa bit, used for subnormals
  always_comb begin
    lead = 4'd0;
    for (int b = 0; b < 10; b++) begin
      if (hman[b]) lead = 4'(b);
    end
  end

  assign shifted = {1'b0, hman} << (4'd10 - lead);
  assign den_exp = 8'd103 + {4'd0, lead};

  always_comb begin
    if (hexp == 5'd0) begin
      if (hman == 10'd0) f_out = {sgn, 31'd0};
      else               f_out = {sgn, den_exp, shifted[9:0], 13'd0};
    end else if (hexp == 5'd31) begin
      f_out = {sgn, 8'hFF, hman, 13'd0};
    end else begin
      f_out = {sgn, {3'd0, hexp} + 8'd112, hman, 13'd0};
    end
  end
endmodule

// File: rtl/gfxu_lane_builder.sv
module gfxu_lane_builder
  import gfxu_pkg::*;
#(
  parameter int unsigned TYPE_W = 3
) (
  input  logic [VEC_W-1:0]  src,
  input  logic [TYPE_W-1:0] kind,
  output unpack_res_t       res
);
  localparam int unsigned NHALF = 4;

  logic [WORD_W-1:0] w2, w3;
  logic [HALF_W-1:0] hin  [NHALF];
  logic [WORD_W-1:0] hout [NHALF];
  logic [WORD_W-1:0] lane [LANES];
  logic [WORD_W-1:0] short_hi, short_lo;
  logic              bad;

  assign w2 = src[2*WORD_W +: WORD_W];
  assign w3 = src[3*WORD_W +: WORD_W];

  assign hin[0] = w2[31:16];
  assign hin[1] = w2[15:0];
  assign hin[2] = w3[31:16];
  assign hin[3] = w3[15:0];

  genvar g;
  generate
    for (g = 0; g < NHALF; g++) begin : g_cvt
      gfxu_half_to_single u_cvt (
        .h_in  (hin[g]),
        .f_out (hout[g])
      );
    end
  endgenerate

  assign short_hi = F_THREE + {{16{w3[31]}}, w3[31:16]};
  assign short_lo = F_THREE + {{16{w3[15]}}, w3[15:0]};

  always_comb begin
    bad = 1'b0;
    for (int k = 0; k < LANES; k++) lane[k] = F_ZERO;
    if (kind == TYPE_W'(KIND_COLOR)) begin
      lane[0] = F_ONE | {24'd0, w3[23:16]};
      lane[1] = F_ONE | {24'd0, w3[15:8]};
      lane[2] = F_ONE | {24'd0, w3[7:0]};
      lane[3] = F_ONE | {24'd0, w3[31:24]};
    end else if (kind == TYPE_W'(KIND_SHORT2)) begin
      lane[0] = short_hi;
      lane[1] = short_lo;
      lane[2] = F_ZERO;
      lane[3] = F_ONE;
    end else if (kind == TYPE_W'(KIND_HALF2)) begin
      lane[0] = hout[2];
      lane[1] = hout[3];
      lane[2] = F_ZERO;
      lane[3] = F_ONE;
    end else if (kind == TYPE_W'(KIND_HALF4)) begin
      for (int k = 0; k < LANES; k++) lane[k] = hout[k];
    end else begin
      bad = 1'b1;
    end
  end

  always_comb begin
    res.err = bad;
    for (int k = 0; k < LANES; k++) res.data[k*WORD_W +: WORD_W] = lane[k];
  end
endmodule

// File: rtl/gfxu_out_stage.sv
module gfxu_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (in_ready) vld_q <= in_valid;
      if (in_valid && in_ready) data_q <= in_data;
    end
  end
endmodule

// File: rtl/gfx_unpack_unit.sv
module gfx_unpack_unit
  import gfxu_pkg::*;
#(
  parameter int unsigned TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [127:0]      in_src,
  input  logic [TYPE_W-1:0] in_kind,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [127:0]      out_data,
  output logic              out_err
);
  localparam int unsigned PAY_W = VEC_W + 1;

  unpack_res_t      comb_res;
  logic [PAY_W-1:0] pay_q;

  gfxu_lane_builder #(.TYPE_W(TYPE_W)) u_build (
    .src  (in_src),
    .kind (in_kind),
    .res  (comb_res)
  );

  gfxu_out_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (comb_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_q)
  );

  assign out_err  = pay_q[PAY_W-1];
  assign out_data = pay_q[VEC_W-1:0];
endmodule

// File: rtl/gfxu_unpack_chk.sv
module gfxu_unpack_chk #(
  parameter int unsigned TYPE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [TYPE_W-1:0] in_kind,
  input logic              out_valid,
  input logic              out_ready,
  input logic [127:0]      out_data,
  input logic              out_err
);
  logic take;
  assign take = in_valid && in_ready;

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  assert_color_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind == TYPE_W'(0)) |=>
      (out_data[31:8] == 24'h3F8000 && out_data[63:40] == 24'h3F8000 &&
       out_data[95:72] == 24'h3F8000 && out_data[127:104] == 24'h3F8000));

  assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_kind == TYPE_W'(1) || in_kind == TYPE_W'(3))) |=>
      (out_data[127:64] == {32'h3F80_0000, 32'h0000_0000}));

  assert_zero_on_err_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_data == 128'd0));

  assert_no_err_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_kind == TYPE_W'(0) || in_kind == TYPE_W'(5))) |=> !out_err);
endmodule

bind gfx_unpack_unit gfxu_unpack_chk #(.TYPE_W(TYPE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_kind   (in_kind),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_err   (out_err)
);

// File: tb/gfx_unpack_unit_tb.sv
module gfx_unpack_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_src = '0;
  logic [2:0]   in_kind = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;
  logic         out_err;

  int n_chk = 0;
  int n_fail = 0;
  logic         hold_mode = 1'b0;
  logic [7:0]   lfsr = 8'h5A;
  logic         prev_stall = 1'b0;
  logic [128:0] prev_pay = '0;
  logic [128:0] exp_q [$];
  string        tag_q [$];

  always #4 clk = ~clk;

  gfx_unpack_unit #(.TYPE_W(3)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_src (in_src), .in_kind (in_kind),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_data (out_data), .out_err (out_err)
  );

  task automatic check(input bit ok, input string tag, input logic [128:0] act, input logic [128:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] vec(input logic [31:0] w3, input logic [31:0] w2,
                                       input logic [31:0] w1, input logic [31:0] w0);
    return {w3, w2, w1, w0};
  endfunction

  task automatic send(input logic [127:0] src, input logic [2:0] k,
                      input logic [127:0] exp, input logic e, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_src   = src;
    in_kind  = k;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    exp_q.push_back({e, exp});
    tag_q.push_back(tag);
    #1;
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = hold_mode ? 1'b0 : (lfsr[0] | lfsr[1]);
      if (prev_stall)
        check(out_valid && {out_err, out_data} == prev_pay, "R2 hold",
              {out_err, out_data}, prev_pay);
      prev_stall = out_valid && !out_ready;
      prev_pay   = {out_err, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected result", {out_err, out_data}, '0);
        end else begin
          logic [128:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_err, out_data} === e, t, {out_err, out_data}, e);
        end
      end
    end
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R3 reset state", {127'd0, out_valid, in_ready}, 129'd1);

    // R4 colour, R12 junk in unread words
    send(vec(32'h04010203, 32'hCDCDCDCD, 32'hCDCDCDCD, 32'hCDCDCDCD), 3'd0,
         vec(32'h3F800004, 32'h3F800003, 32'h3F800002, 32'h3F800001), 1'b0, "R4 colour");
    send(vec(32'h04010203, 32'h0, 32'hFFFFFFFF, 32'h12345678), 3'd0,
         vec(32'h3F800004, 32'h3F800003, 32'h3F800002, 32'h3F800001), 1'b0, "R12 colour junk");
    send(vec(32'hFF00807F, 32'h0, 32'h0, 32'h0), 3'd0,
         vec(32'h3F8000FF, 32'h3F80007F, 32'h3F800080, 32'h3F800000), 1'b0, "R4 colour extremes");
    // R5 / R6 integer pair
    send(vec(32'h7FFF8001, 32'hCDCDCDCD, 32'hCDCDCDCD, 32'hCDCDCDCD), 3'd1,
         vec(32'h3F800000, 32'h0, 32'h403F8001, 32'h40407FFF), 1'b0, "R5 R6 short 7FFF/8001");
    send(vec(32'h4000C000, 32'h0, 32'h0, 32'h0), 3'd1,
         vec(32'h3F800000, 32'h0, 32'h403FC000, 32'h40404000), 1'b0, "R5 short 4000/C000");
    send(vec(32'h0000FFFF, 32'hAAAAAAAA, 32'h55555555, 32'h1), 3'd1,
         vec(32'h3F800000, 32'h0, 32'h403FFFFF, 32'h40400000), 1'b0, "R12 R5 short 0/FFFF");
    // R7 half pair
    send(vec(32'h3800B800, 32'hCDCDCDCD, 32'hCDCDCDCD, 32'hCDCDCDCD), 3'd3,
         vec(32'h3F800000, 32'h0, 32'hBF000000, 32'h3F000000), 1'b0, "R7 R6 half pair");
    // R8 / R9 four halves
    send(vec(32'h3802B803, 32'h3800B801, 32'hCDCDCDCD, 32'hCDCDCDCD), 3'd5,
         vec(32'hBF006000, 32'h3F004000, 32'hBF002000, 32'h3F000000), 1'b0, "R8 R9 four halves");
    send(vec(32'h3C007BFF, 32'h03FF0200, 32'h0, 32'h0), 3'd5,
         vec(32'h477FE000, 32'h3F800000, 32'h38000000, 32'h387FC000), 1'b0, "R10 R9 subnormal/normal");
    send(vec(32'h7C00FE01, 32'h00018000, 32'h0, 32'h0), 3'd5,
         vec(32'hFFC02000, 32'h7F800000, 32'h80000000, 32'h33800000), 1'b0, "R11 R10 inf nan zero");
    // R13 unsupported kinds
    for (int k = 2; k < 8; k++) begin
      if (k != 3 && k != 5)
        send(vec(32'h7FFF8001, 32'hFFFFFFFF, 32'h1, 32'h2), 3'(k),
             128'd0, 1'b1, "R13 unsupported kind");
    end

    // R2 / R1 forced stall
    wait (exp_q.size() == 0);
    hold_mode = 1'b1;
    send(vec(32'h3800B800, 32'h0, 32'h0, 32'h0), 3'd3,
         vec(32'h3F800000, 32'h0, 32'hBF000000, 32'h3F000000), 1'b0, "R1 result after stall");
    repeat (2) @(negedge clk);
    #2;
    check(out_valid && !in_ready, "R1 back-pressure", {127'd0, out_valid, in_ready}, 129'd2);
    repeat (4) @(negedge clk);
    hold_mode = 1'b0;

    // burst mixed kinds under random ready
    for (int i = 0; i < 20; i++) begin
      send(vec(32'h04010203, 32'(i), 32'hCDCDCDCD, 32'(i * 7)), 3'd0,
           vec(32'h3F800004, 32'h3F800003, 32'h3F800002, 32'h3F800001), 1'b0, "R1 R4 burst");
      send(vec(32'h7FFF8001, 32'(i), 32'h0, 32'h0), 3'd1,
           vec(32'h3F800000, 32'h0, 32'h403F8001, 32'h40407FFF), 1'b0, "R1 R5 burst");
    end

    repeat (200) begin
      @(negedge clk);
      if (exp_q.size() == 0) break;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 all results delivered", 129'(exp_q.size()), 129'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule